// File: doc/BRIEF.md
# Integer Execute Unit with Immediates

This block is the integer execute stage of a 32-bit load/store processor. Each cycle it takes a 32-bit instruction word and the values read for its two source registers. It returns the result, the destination register and a write enable. It also keeps a 4-bit condition-code register that flag-setting instructions update on the clock edge. The result path has no registers. Only the condition codes are state.

Two instruction shapes are accepted. The register-operation shape covers several kinds of operation:

- addition and subtraction, each with a variant that also consumes the held carry flag;
- six bitwise logic functions, three of which invert the second operand first;
- three shifts.

Its second operand is either a register or a sign-extended 13-bit immediate, chosen by one bit of the instruction. The upper-immediate shape places a 22-bit constant in the top bits of the destination. Any other encoding is reported as illegal, and that instruction has no effect.

Top module: `int_exec_unit`

## Requirements
- R1: Register-operation shape: bits [31:30] = 2'b10, destination [29:25], operation code [24:19], first source [18:14], operand select bit 13. When `valid_i` is high and the instruction is legal with a nonzero destination, `wr_en_o` is high and `wr_addr_o` equals the destination field, in the same cycle.
- R2: With bit 13 = 0 the second operand is the register named by bits [4:0] (value on `src2_val_i`). With bit 13 = 1 it is bits [12:0] sign-extended to 32 bits.
- R3: A source field of 0 reads as zero whatever value is supplied on its value input. A destination of 0 keeps `wr_en_o` low.
- R4: Arithmetic codes: 0x00 add (a+b), 0x08 add with carry (a+b+C), 0x04 subtract (a-b), 0x0C subtract with borrow (a-b-C). C is the carry flag held before the instruction.
- R5: Logic codes: 0x01 a&b, 0x05 a&~b, 0x02 a|b, 0x06 a|~b, 0x03 a^b, 0x07 ~(a^b).
- R6: Shift codes: 0x25 left, 0x26 logical right, 0x27 arithmetic right. The amount is the low 5 bits of the second operand. The right logical shift fills with zeros and the arithmetic shift fills with the sign bit.
- R7: Upper-immediate shape: bits [31:30] = 2'b00 and [24:22] = 3'b100. The result is bits [21:0] followed by ten zero bits, written to [29:25]. The condition codes are unchanged.
- R8: Adding 0x10 to any arithmetic code makes it flag-setting. On the next clock edge `cc_o` = {N,Z,V,C}: N is result bit 31 and Z means the result is zero. C is the unsigned carry-out for additions and the unsigned borrow for subtractions. V is set on signed overflow.
- R9: Adding 0x10 to any logic code makes it flag-setting. N and Z follow the result, and V and C are cleared.
- R10: The condition codes change only on a clock edge with `valid_i` high and a legal flag-setting instruction. Non-flag codes, shifts and idle cycles leave them unchanged. With `valid_i` low, `wr_en_o` and `illegal_o` are low.
- R11: With `valid_i` high, the following raise `illegal_o`, keep `wr_en_o` low and leave the condition codes unchanged:
  - bits [31:30] of 01 or 11;
  - shape 00 with [24:22] other than 100;
  - any register-operation code not listed in R4 to R6 or R8 to R9.
- R12: After reset the condition codes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction present this cycle |
| instr_i | input | 32 | Instruction word |
| src1_val_i | input | 32 | Value of the register named by [18:14] |
| src2_val_i | input | 32 | Value of the register named by [4:0] |
| result_o | output | 32 | Computed result |
| wr_en_o | output | 1 | Destination write enable |
| wr_addr_o | output | 5 | Destination register index |
| illegal_o | output | 1 | Unrecognised encoding |
| cc_o | output | 4 | Condition codes {N,Z,V,C} |

## Verification
A flag-setting add-with-carry or subtract-with-borrow does two things in one cycle. It consumes the held carry flag and it also replaces that flag, so a read and an overwrite of the same state coincide. The bench provokes this with back-to-back chains of such instructions on operands near the 32-bit boundaries (0, 1, 0x7FFFFFFF, 0x80000000, 0xFFFFFFFF). Idle and illegal cycles are interleaved, during which the carry must survive. A behavioural model, built on 64-bit integer arithmetic, judges every cycle's result and the flags seen after the edge.

// File: rtl/exu_pkg.sv
package exu_pkg;

    localparam int DATA_W = 32;
    localparam int REG_AW = 5;
    localparam int SIMM_W = 13;
    localparam int UIMM_W = 22;
    localparam int CC_W   = 4;
    localparam int OPF_W  = 6;

    // instruction shape selector values
    localparam logic [1:0] FMT_UPPER = 2'b00;
    localparam logic [1:0] FMT_REGOP = 2'b10;
    localparam logic [2:0] UPPER_SUB = 3'b100;

    // low four bits of non-shift operation codes; bit 4 selects flag update
    localparam logic [3:0] OPC_ADD  = 4'h0;
    localparam logic [3:0] OPC_AND  = 4'h1;
    localparam logic [3:0] OPC_OR   = 4'h2;
    localparam logic [3:0] OPC_XOR  = 4'h3;
    localparam logic [3:0] OPC_SUB  = 4'h4;
    localparam logic [3:0] OPC_ANDN = 4'h5;
    localparam logic [3:0] OPC_ORN  = 4'h6;
    localparam logic [3:0] OPC_XNOR = 4'h7;
    localparam logic [3:0] OPC_ADDC = 4'h8;
    localparam logic [3:0] OPC_SUBC = 4'hC;

    // full shift codes
    localparam logic [OPF_W-1:0] OPC_SLL = 6'h25;
    localparam logic [OPF_W-1:0] OPC_SRL = 6'h26;
    localparam logic [OPF_W-1:0] OPC_SRA = 6'h27;

    typedef enum logic [3:0] {
        OP_ADD, OP_ADDC, OP_SUB, OP_SUBC,
        OP_AND, OP_ANDN, OP_OR, OP_ORN, OP_XOR, OP_XNOR,
        OP_SLL, OP_SRL, OP_SRA, OP_UIMM
    } alu_op_e;

    typedef struct packed {
        alu_op_e             op;
        logic                set_cc;
        logic                legal;
        logic                imm_sel;
        logic [REG_AW-1:0]   rd;
        logic [REG_AW-1:0]   rs1;
        logic [REG_AW-1:0]   rs2;
        logic [SIMM_W-1:0]   simm;
        logic [UIMM_W-1:0]   uimm;
    } dec_t;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_t;

endpackage

// File: rtl/exu_decode.sv
module exu_decode
    import exu_pkg::*;
(
    input  logic [DATA_W-1:0] instr_i,
    output dec_t              dec_o
);

    logic [OPF_W-1:0] opf;

    always_comb begin
        opf          = instr_i[24:19];
        dec_o        = '0;
        dec_o.op     = OP_ADD;
        dec_o.rd     = instr_i[29:25];
        dec_o.rs1    = instr_i[18:14];
        dec_o.rs2    = instr_i[4:0];
        dec_o.imm_sel = instr_i[13];
        dec_o.simm   = instr_i[12:0];
        dec_o.uimm   = instr_i[21:0];

        unique case (instr_i[31:30])
            FMT_UPPER: begin
                if (instr_i[24:22] == UPPER_SUB) begin
                    dec_o.op    = OP_UIMM;
                    dec_o.legal = 1'b1;
                end
            end
            FMT_REGOP: begin
                if (!opf[5]) begin
                    dec_o.legal  = 1'b1;
                    dec_o.set_cc = opf[4];
                    case (opf[3:0])
                        OPC_ADD:  dec_o.op = OP_ADD;
                        OPC_ADDC: dec_o.op = OP_ADDC;
                        OPC_SUB:  dec_o.op = OP_SUB;
                        OPC_SUBC: dec_o.op = OP_SUBC;
                        OPC_AND:  dec_o.op = OP_AND;
                        OPC_ANDN: dec_o.op = OP_ANDN;
                        OPC_OR:   dec_o.op = OP_OR;
                        OPC_ORN:  dec_o.op = OP_ORN;
                        OPC_XOR:  dec_o.op = OP_XOR;
                        OPC_XNOR: dec_o.op = OP_XNOR;
                        default: begin
                            dec_o.legal  = 1'b0;
                            dec_o.set_cc = 1'b0;
                        end
                    endcase
                end else begin
                    dec_o.legal = 1'b1;
                    case (opf)
                        OPC_SLL: dec_o.op = OP_SLL;
                        OPC_SRL: dec_o.op = OP_SRL;
                        OPC_SRA: dec_o.op = OP_SRA;
                        default: dec_o.legal = 1'b0;
                    endcase
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/exu_operand.sv
module exu_operand
    import exu_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int AW = REG_AW,
    parameter int IW = SIMM_W
) (
    input  logic [AW-1:0] rs1_i,
    input  logic [AW-1:0] rs2_i,
    input  logic          imm_sel_i,
    input  logic [IW-1:0] simm_i,
    input  logic [W-1:0]  src1_val_i,
    input  logic [W-1:0]  src2_val_i,
    output logic [W-1:0]  op_a_o,
    output logic [W-1:0]  op_b_o
);

    localparam int EXT_W = W - IW;

    logic [W-1:0] imm_ext;
    logic [W-1:0] reg_b;

    // register index zero always reads as zero
    assign op_a_o  = (rs1_i == '0) ? '0 : src1_val_i;
    assign reg_b   = (rs2_i == '0) ? '0 : src2_val_i;
    assign imm_ext = {{EXT_W{simm_i[IW-1]}}, simm_i};
    assign op_b_o  = imm_sel_i ? imm_ext : reg_b;

endmodule

// File: rtl/exu_alu.sv
module exu_alu
    import exu_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int UW = UIMM_W
) (
    input  alu_op_e        op_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic [UW-1:0]  uimm_i,
    input  logic           c_i,
    output logic [W-1:0]   res_o,
    output cc_t            flags_o
);

    localparam int SHW = $clog2(W);
    localparam int LOW = W - UW;

    logic [W:0]     sum_w;
    logic [W:0]     dif_w;
    logic           cin;
    logic [SHW-1:0] amt;
    logic           is_add;
    logic           is_sub;

    always_comb begin
        cin    = (op_i == OP_ADDC || op_i == OP_SUBC) ? c_i : 1'b0;
        sum_w  = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin};
        dif_w  = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin};
        amt    = b_i[SHW-1:0];
        is_add = 1'b0;
        is_sub = 1'b0;
        res_o  = '0;

        unique case (op_i)
            OP_ADD, OP_ADDC: begin
                res_o  = sum_w[W-1:0];
                is_add = 1'b1;
            end
            OP_SUB, OP_SUBC: begin
                res_o  = dif_w[W-1:0];
                is_sub = 1'b1;
            end
            OP_AND:  res_o = a_i & b_i;
            OP_ANDN: res_o = a_i & ~b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_ORN:  res_o = a_i | ~b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_XNOR: res_o = ~(a_i ^ b_i);
            OP_SLL:  res_o = a_i << amt;
            OP_SRL:  res_o = a_i >> amt;
            OP_SRA:  res_o = $unsigned($signed(a_i) >>> amt);
            OP_UIMM: res_o = {uimm_i, {LOW{1'b0}}};
            default: res_o = '0;
        endcase

        flags_o.n = res_o[W-1];
        flags_o.z = (res_o == '0);
        if (is_add) begin
            flags_o.v = (a_i[W-1] == b_i[W-1]) && (res_o[W-1] != a_i[W-1]);
            flags_o.c = sum_w[W];
        end else if (is_sub) begin
            flags_o.v = (a_i[W-1] != b_i[W-1]) && (res_o[W-1] != a_i[W-1]);
            flags_o.c = dif_w[W];
        end else begin
            flags_o.v = 1'b0;
            flags_o.c = 1'b0;
        end
    end

endmodule

// File: rtl/exu_ccreg.sv
module exu_ccreg
    import exu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic upd_i,
    input  cc_t  nxt_i,
    output cc_t  cc_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cc_o <= '0;
        end else if (upd_i) begin
            cc_o <= nxt_i;
        end
    end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import exu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid_i,
    input  logic [DATA_W-1:0]   instr_i,
    input  logic [DATA_W-1:0]   src1_val_i,
    input  logic [DATA_W-1:0]   src2_val_i,
    output logic [DATA_W-1:0]   result_o,
    output logic                wr_en_o,
    output logic [REG_AW-1:0]   wr_addr_o,
    output logic                illegal_o,
    output logic [CC_W-1:0]     cc_o
);

    dec_t              dec;
    logic [DATA_W-1:0] op_a;
    logic [DATA_W-1:0] op_b;
    cc_t               flags_nxt;
    cc_t               cc_q;
    logic              cc_upd;

    exu_decode u_decode (
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    exu_operand #(
        .W  (DATA_W),
        .AW (REG_AW),
        .IW (SIMM_W)
    ) u_operand (
        .rs1_i      (dec.rs1),
        .rs2_i      (dec.rs2),
        .imm_sel_i  (dec.imm_sel),
        .simm_i     (dec.simm),
        .src1_val_i (src1_val_i),
        .src2_val_i (src2_val_i),
        .op_a_o     (op_a),
        .op_b_o     (op_b)
    );

    exu_alu #(
        .W  (DATA_W),
        .UW (UIMM_W)
    ) u_alu (
        .op_i    (dec.op),
        .a_i     (op_a),
        .b_i     (op_b),
        .uimm_i  (dec.uimm),
        .c_i     (cc_q.c),
        .res_o   (result_o),
        .flags_o (flags_nxt)
    );

    assign cc_upd = valid_i && dec.legal && dec.set_cc;

    exu_ccreg u_ccreg (
        .clk   (clk),
        .rst_n (rst_n),
        .upd_i (cc_upd),
        .nxt_i (flags_nxt),
        .cc_o  (cc_q)
    );

    assign wr_addr_o = dec.rd;
    assign wr_en_o   = valid_i && dec.legal && (dec.rd != '0);
    assign illegal_o = valid_i && !dec.legal;
    assign cc_o      = cc_q;

endmodule

// File: rtl/exu_checker.sv
module exu_checker
    import exu_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                valid_i,
    input logic [DATA_W-1:0]   instr_i,
    input logic [DATA_W-1:0]   result_o,
    input logic                wr_en_o,
    input logic [REG_AW-1:0]   wr_addr_o,
    input logic                illegal_o,
    input logic [CC_W-1:0]     cc_o
);

    localparam int LOW = DATA_W - UIMM_W;

    logic regop, upper, setcc_op, logic_op;

    assign regop    = valid_i && (instr_i[31:30] == FMT_REGOP);
    assign upper    = valid_i && (instr_i[31:30] == FMT_UPPER) && (instr_i[24:22] == UPPER_SUB);
    assign setcc_op = regop && !illegal_o && instr_i[23];
    assign logic_op = setcc_op && !instr_i[22] && (instr_i[20:19] != 2'b00);

    assert_illegal_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !wr_en_o);

    assert_illegal_keeps_cc_R11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |=> $stable(cc_o));

    assert_zero_dest_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (wr_addr_o != '0));

    assert_plain_keeps_cc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (regop && !instr_i[23]) |=> $stable(cc_o));

    assert_idle_keeps_cc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(cc_o));

    assert_idle_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |-> (!wr_en_o && !illegal_o));

    assert_upper_low_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        upper |-> (result_o[LOW-1:0] == '0) && (result_o[DATA_W-1:LOW] == instr_i[UIMM_W-1:0]));

    assert_upper_keeps_cc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        upper |=> $stable(cc_o));

    assert_logic_clears_vc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        logic_op |=> (cc_o[1:0] == 2'b00));

    assert_nz_follow_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        setcc_op |=> (cc_o[2] == ($past(result_o) == '0)) && (cc_o[3] == $past(result_o[DATA_W-1])));

endmodule

bind int_exec_unit exu_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (valid_i),
    .instr_i   (instr_i),
    .result_o  (result_o),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o),
    .illegal_o (illegal_o),
    .cc_o      (cc_o)
);

// File: tb/int_exec_unit_tb_top.sv
`timescale 1ns/1ps
module int_exec_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] src1_val_i = '0;
    logic [31:0] src2_val_i = '0;
    logic [31:0] result_o;
    logic        wr_en_o;
    logic [4:0]  wr_addr_o;
    logic        illegal_o;
    logic [3:0]  cc_o;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 0;
    logic [3:0] m_cc = 4'h0;
    string cc_tag = "R12";

    always #4 clk = ~clk;

    int_exec_unit dut_i (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
        .src1_val_i(src1_val_i), .src2_val_i(src2_val_i), .result_o(result_o),
        .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .illegal_o(illegal_o), .cc_o(cc_o)
    );

    localparam longint SMAX = 64'sd2147483647;
    localparam longint SMIN = -64'sd2147483648;

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input logic [5:0] op, input logic [4:0] rd, input logic [4:0] rs1, input logic [4:0] rs2);
        return {2'b10, rd, op, rs1, 1'b0, 8'h00, rs2};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rd, input logic [4:0] rs1, input logic [12:0] imm);
        return {2'b10, rd, op, rs1, 1'b1, imm};
    endfunction

    function automatic logic [31:0] enc_u(input logic [4:0] rd, input logic [21:0] imm);
        return {2'b00, rd, 3'b100, imm};
    endfunction

    // behavioural reference built from the requirements
    task automatic model(input logic [31:0] ins, input logic [31:0] a_in, input logic [31:0] b_in,
                         input logic [3:0] cc_in, input bit v_in,
                         output logic [31:0] res, output bit we, output bit ill,
                         output logic [3:0] cc_nx, output string tag);
        logic [31:0] a, b;
        logic [5:0]  op;
        bit          legal, setcc, vf, cf, arith;
        longint      ua, ub, sa, sb, ex, exs;
        int          cin;
        res = '0; legal = 0; setcc = 0; vf = 0; cf = 0; arith = 0; tag = "R11";
        cc_nx = cc_in;
        cin = int'(cc_in[0]);
        a  = (ins[18:14] == 5'd0) ? 32'd0 : a_in;
        b  = ins[13] ? {{19{ins[12]}}, ins[12:0]} : ((ins[4:0] == 5'd0) ? 32'd0 : b_in);
        ua = longint'({32'd0, a});
        ub = longint'({32'd0, b});
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        op = ins[24:19];
        if (ins[31:30] == 2'b00 && ins[24:22] == 3'b100) begin
            legal = 1; res = {ins[21:0], 10'd0}; tag = "R7";
        end else if (ins[31:30] == 2'b10) begin
            if (!op[5]) begin
                legal = 1; setcc = op[4]; tag = op[4] ? "R9" : "R5";
                case (op[3:0])
                    4'h0, 4'h8: begin
                        if (op[3] == 1'b0) cin = 0;
                        ex = ua + ub + cin; exs = sa + sb + cin;
                        res = ex[31:0]; cf = (ex > 64'sd4294967295); arith = 1;
                    end
                    4'h4, 4'hC: begin
                        if (op[3] == 1'b0) cin = 0;
                        ex = ua - ub - cin; exs = sa - sb - cin;
                        res = ex[31:0]; cf = (ex < 0); arith = 1;
                    end
                    4'h1: res = a & b;
                    4'h5: res = a & ~b;
                    4'h2: res = a | b;
                    4'h6: res = a | ~b;
                    4'h3: res = a ^ b;
                    4'h7: res = ~(a ^ b);
                    default: begin legal = 0; setcc = 0; tag = "R11"; end
                endcase
                if (arith) begin
                    vf = (exs > SMAX) || (exs < SMIN);
                    tag = setcc ? "R8" : "R4";
                end
            end else begin
                legal = 1; tag = "R6";
                case (op)
                    6'h25: res = a << b[4:0];
                    6'h26: res = a >> b[4:0];
                    6'h27: res = $unsigned($signed(a) >>> b[4:0]);
                    default: begin legal = 0; tag = "R11"; end
                endcase
            end
        end
        if (legal && setcc) cc_nx = {res[31], res == 32'd0, vf, cf};
        if (!v_in) begin
            we = 0; ill = 0; cc_nx = cc_in; tag = "R10";
        end else begin
            ill = !legal;
            we  = legal && (ins[29:25] != 5'd0);
        end
    endtask

    task automatic run(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b, input bit v);
        logic [31:0] e_res;
        bit          e_we, e_ill;
        logic [3:0]  e_cc;
        string       tag;
        @(negedge clk);
        valid_i = v; instr_i = ins; src1_val_i = a; src2_val_i = b;
        #2;
        check(cc_tag, "cc", {28'd0, cc_o}, {28'd0, m_cc});
        model(ins, a, b, m_cc, v, e_res, e_we, e_ill, e_cc, tag);
        if (v && !e_ill) check(ins[13] ? "R2" : tag, "result", result_o, e_res);
        check((ins[29:25] == 5'd0) ? "R3" : "R1", "wr_en", {31'd0, wr_en_o}, {31'd0, e_we});
        if (e_we) check("R1", "wr_addr", {27'd0, wr_addr_o}, {27'd0, ins[29:25]});
        check(v ? "R11" : "R10", "illegal", {31'd0, illegal_o}, {31'd0, e_ill});
        m_cc   = e_cc;
        cc_tag = tag;
    endtask

    function automatic logic [31:0] pick();
        case ($urandom % 7)
            0: return 32'h0000_0000;
            1: return 32'h7FFF_FFFF;
            2: return 32'h8000_0000;
            3: return 32'hFFFF_FFFF;
            4: return 32'h0000_0001;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [5:0] ops [23];
        ops = '{6'h00, 6'h01, 6'h02, 6'h03, 6'h04, 6'h05, 6'h06, 6'h07, 6'h08, 6'h0C,
                6'h10, 6'h11, 6'h12, 6'h13, 6'h14, 6'h15, 6'h16, 6'h17, 6'h18, 6'h1C,
                6'h25, 6'h26, 6'h27};
        repeat (3) @(posedge clk);
        #1;
        check("R12", "cc after reset", {28'd0, cc_o}, 32'd0);
        rst_n = 1'b1;

        // R4 plain add, explicit value
        run(enc_r(6'h00, 5'd3, 5'd1, 5'd2), 32'd5, 32'd7, 1);
        check("R4", "add 5+7", result_o, 32'd12);
        // R8 signed overflow on add: expect N=1 Z=0 V=1 C=0
        run(enc_r(6'h10, 5'd3, 5'd1, 5'd2), 32'h7FFF_FFFF, 32'd1, 1);
        run(32'd0, 32'd0, 32'd0, 0);
        check("R8", "cc add overflow", {28'd0, cc_o}, 32'hA);
        // R8 borrow: 0-1 -> N=1 C=1
        run(enc_i(6'h14, 5'd4, 5'd1, 13'd1), 32'd0, 32'd0, 1);
        check("R2", "sub imm result", result_o, 32'hFFFF_FFFF);
        run(32'd0, 32'd0, 32'd0, 0);
        check("R8", "cc borrow", {28'd0, cc_o}, 32'h9);
        // R4 add with carry uses held C=1
        run(enc_r(6'h08, 5'd5, 5'd1, 5'd2), 32'd10, 32'd20, 1);
        check("R4", "addc with C", result_o, 32'd31);
        // R2 negative immediate sign extension
        run(enc_i(6'h00, 5'd6, 5'd1, 13'h1FFF), 32'd100, 32'd0, 1);
        check("R2", "add imm -1", result_o, 32'd99);
        // R3 zero source reads zero, zero destination not written
        run(enc_r(6'h02, 5'd0, 5'd0, 5'd2), 32'hDEAD_BEEF, 32'h0000_00F0, 1);
        check("R3", "r0 source", result_o, 32'h0000_00F0);
        check("R3", "r0 dest wr_en", {31'd0, wr_en_o}, 32'd0);
        // R9 logic flag op clears V and C, sets Z
        run(enc_r(6'h15, 5'd7, 5'd1, 5'd2), 32'h0F0F, 32'hFFFF, 1);
        check("R5", "andn", result_o, 32'd0);
        run(32'd0, 32'd0, 32'd0, 0);
        check("R9", "cc logic zero", {28'd0, cc_o}, 32'h4);
        // R6 arithmetic right shift of negative value
        run(enc_i(6'h27, 5'd8, 5'd1, 13'd4), 32'h8000_0000, 32'd0, 1);
        check("R6", "sra", result_o, 32'hF800_0000);
        run(enc_r(6'h26, 5'd8, 5'd1, 5'd2), 32'h8000_0000, 32'd36, 1);
        check("R6", "srl amount low bits", result_o, 32'h0800_0000);
        // R7 upper immediate
        run(enc_u(5'd9, 22'h3FFFFF), 32'd0, 32'd0, 1);
        check("R7", "upper imm", result_o, 32'hFFFF_FC00);
        // R11 illegal forms
        run(enc_r(6'h09, 5'd9, 5'd1, 5'd2), 32'd1, 32'd1, 1);
        check("R11", "illegal flag", {31'd0, illegal_o}, 32'd1);
        run({2'b01, 30'h123}, 32'd1, 32'd1, 1);
        run({2'b00, 5'd3, 3'b010, 22'h1}, 32'd1, 32'd1, 1);

        // carry-chain stress plus random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] ins;
            int sel;
            sel = $urandom % 12;
            ins = $urandom;
            if (sel == 0) ins[31:30] = 2'b00;
            else if (sel == 1) ins = ins;
            else if (sel < 5) begin
                ins[31:30] = 2'b10;
                ins[24:19] = ($urandom % 2) ? 6'h18 : 6'h1C;
            end else begin
                ins[31:30] = 2'b10;
                ins[24:19] = ($urandom % 8 == 0) ? 6'($urandom) : ops[$urandom % 23];
            end
            if ($urandom % 8 == 0) ins[18:14] = 5'd0;
            run(ins, pick(), pick(), ($urandom % 10) != 0);
        end
        run(32'd0, 32'd0, 32'd0, 0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule